// File: doc/BRIEF.md
# Dual-Output PWM Timer Channel

This block is one timer channel. It has a single 16-bit up-counter that can drive two pulse-width-modulated outputs. Output 0 takes its period from compare register A and its duty from compare register B. Output 1 takes its period from compare register C and its duty from compare register D. Only one of the two period registers clears the counter, and a bit in the control word selects which one. The counter advances on a prescaled tick. The tick divides the clock by 1, 4, 16 or 64. Both outputs share the prescaler and the control word.

Software programs the channel through a simple write port. It writes the control word, an I/O mode byte for each output and the four compare values. An output whose mode byte holds the PWM code drives its pin. Any other code turns the pad driver off, so the pin is high-impedance. The counter runs whenever at least one output is enabled. While the counter runs, the control word is locked. To change the prescaler or the clear source, software turns both outputs off, writes the control word, and turns the outputs back on.

Top module: `dual_pwm_timer`

## Requirements
- R1: After reset, both pad enables `pwm_oe` are low, both `pwm_out` bits are low, the counter is stopped at zero, the prescale code is 0 and the clear source is A.
- R2: Control word address 0: bits [1:0] hold the prescale code c. While running, the counter advances once every 4^c clocks.
- R3: Control bit [2] selects the clear source: 0 clears on a match with A, 1 clears on a match with C. The counter counts 0..P and then wraps, so one period lasts (P+1)*4^c clocks.
- R4: An enabled output is high while the count is below its duty value, so it is high for min(D, P+1)*4^c clocks per period. A duty of 0 keeps it low for the whole period. A duty above the period keeps it high for the whole period.
- R5: I/O mode address 1: data bits [15:8] set the mode of output 0 and bits [7:0] set the mode of output 1. The code 8'h12 enables the output. Any other code makes its `pwm_oe` bit and its `pwm_out` bit low.
- R6: The counter runs only while at least one output is enabled. When both outputs are off, the counter and the prescaler return to zero, so enabling an output starts a fresh period at count 0 in the cycle after the write.
- R7: A control word write made while the counter runs is dropped. After a later stop and restart, the old prescale code and clear source are still in use.
- R8: Compare addresses 2, 3, 4 and 5 hold A, B, C and D. A write is not buffered: a new duty value affects the output from the cycle after the write.
- R9: With clear source A and both outputs enabled, output 1 compares D against the shared counter, so its high time is min(D, A+1)*4^c clocks per period of A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 I/O modes, 2..5 compares A..D) |
| wr_data | input | 16 | Write data |
| pwm_out | output | 2 | PWM level per output, low while disabled |
| pwm_oe | output | 2 | Pad driver enable per output; the pin is high-impedance when low |

## Verification
The assertions on full and zero duty assume that the count has not already passed the period. That holds only when software changes a period while the counter is stopped, and the sweep keeps to that rule by disabling both outputs before each reprogramming. The control-lock property assumes that the run state seen at a write edge is the one the design used. For that reason the bench drives every write half a cycle before the edge. Measurement windows open right after the enabling write and span exactly two periods. Counting the high samples then checks the period and the duty together.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam logic [7:0] IO_MODE_PWM = 8'h12;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_IO   = 3'd1,
    RA_CMPA = 3'd2,
    RA_CMPB = 3'd3,
    RA_CMPC = 3'd4,
    RA_CMPD = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/pwm2_prescaler.sv
module pwm2_prescaler #(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  localparam int DIV_W = 2 * ((1 << PSC_W) - 1);

  logic [DIV_W-1:0] div_q, div_d, lim;

  // terminal count = 4^psc - 1, built as a run of ones
  always_comb begin
    lim = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (i < 2 * int'(psc)) lim[i] = 1'b1;
    end
  end

  assign tick = run && (div_q == lim);

  always_comb begin
    if (!run)      div_d = '0;
    else if (tick) div_d = '0;
    else           div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/pwm2_counter.sv
module pwm2_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (!run)                 cnt_d = '0;
    else if (!tick)           cnt_d = cnt;
    else if (cnt == period)   cnt_d = '0;
    else                      cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/pwm2_outstage.sv
module pwm2_outstage
  import pwm2_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int IO_W  = 8
) (
  input  logic [IO_W-1:0]  io_mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  output logic             oe,
  output logic             lvl
);
  logic active;

  assign active = (io_mode == IO_W'(IO_MODE_PWM));
  assign oe     = active;
  assign lvl    = active && (cnt < duty);
endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer
  import pwm2_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [1:0]       pwm_out,
  output logic [1:0]       pwm_oe
);
  localparam int N_OUT = 2;
  localparam int N_CMP = 2 * N_OUT;
  localparam int IO_W  = 8;

  // reset synchroniser: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  logic             clr_sel_q, clr_sel_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [IO_W-1:0]  io_q  [N_OUT];
  logic [IO_W-1:0]  io_d  [N_OUT];
  logic [CNT_W-1:0] cmp_q [N_CMP];
  logic [CNT_W-1:0] cmp_d [N_CMP];

  logic             run, tick;
  logic [CNT_W-1:0] cnt_q, period;
  logic [N_OUT-1:0] oe_w, lvl_w;

  assign run = |oe_w;

  always_comb begin
    clr_sel_d = clr_sel_q;
    psc_d     = psc_q;
    io_d      = io_q;
    cmp_d     = cmp_q;
    if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        RA_CTRL: if (!run) begin
          psc_d     = wr_data[PSC_W-1:0];
          clr_sel_d = wr_data[PSC_W];
        end
        RA_IO: begin
          io_d[0] = wr_data[2*IO_W-1:IO_W];
          io_d[1] = wr_data[IO_W-1:0];
        end
        RA_CMPA: cmp_d[0] = wr_data;
        RA_CMPB: cmp_d[1] = wr_data;
        RA_CMPC: cmp_d[2] = wr_data;
        RA_CMPD: cmp_d[3] = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      clr_sel_q <= 1'b0;
      psc_q     <= '0;
      for (int i = 0; i < N_OUT; i++) io_q[i]  <= '0;
      for (int i = 0; i < N_CMP; i++) cmp_q[i] <= '0;
    end else begin
      clr_sel_q <= clr_sel_d;
      psc_q     <= psc_d;
      io_q      <= io_d;
      cmp_q     <= cmp_d;
    end
  end

  assign period = clr_sel_q ? cmp_q[2] : cmp_q[0];

  pwm2_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk  (clk),
    .rst_n(rst_sn),
    .run  (run),
    .psc  (psc_q),
    .tick (tick)
  );

  pwm2_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sn),
    .run   (run),
    .tick  (tick),
    .period(period),
    .cnt   (cnt_q)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    pwm2_outstage #(.CNT_W(CNT_W), .IO_W(IO_W)) u_stage (
      .io_mode(io_q[g]),
      .cnt    (cnt_q),
      .duty   (cmp_q[2*g+1]),
      .oe     (oe_w[g]),
      .lvl    (lvl_w[g])
    );
  end

  assign pwm_out = lvl_w;
  assign pwm_oe  = oe_w;
endmodule

// File: rtl/pwm2_checker.sv
module pwm2_checker #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] per_a,
  input logic [CNT_W-1:0] duty_b,
  input logic [CNT_W-1:0] duty_d,
  input logic             clr_sel,
  input logic [PSC_W-1:0] psc,
  input logic [1:0]       oe,
  input logic [1:0]       out
);
  // R6: an idle counter is parked at zero
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  // R7: control word frozen while the counter runs
  a_r7_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> ($stable(psc) && $stable(clr_sel)));

  // R2: one step per tick below the period
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt != period) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R3: wrap to zero on the period match
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt == period) |=> (cnt == '0));

  // R4: duty above period holds output 0 high
  a_r4_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (oe[0] && !clr_sel && duty_b > per_a && cnt <= per_a) |-> out[0]);

  // R4: zero duty keeps both outputs low
  a_r4_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
    ((oe[0] && duty_b == '0) || (oe[1] && duty_d == '0)) |->
      !((oe[0] && duty_b == '0 && out[0]) || (oe[1] && duty_d == '0 && out[1])));

  // R5: a disabled output never shows a high level
  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out & ~oe) == 2'b00);
endmodule

bind dual_pwm_timer pwm2_checker #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sn),
  .run    (run),
  .tick   (tick),
  .cnt    (cnt_q),
  .period (period),
  .per_a  (cmp_q[0]),
  .duty_b (cmp_q[1]),
  .duty_d (cmp_q[3]),
  .clr_sel(clr_sel_q),
  .psc    (psc_q),
  .oe     (pwm_oe),
  .out    (pwm_out)
);

// File: tb/dual_pwm_timer_bench.sv
module dual_pwm_timer_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  pwm_out, pwm_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dual_pwm_timer u_dual_pwm_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive between edges; returns at the falling edge after the write edge
  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int k, input int n, output int high);
    high = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out[k]) high++;
      @(negedge clk);
    end
  endtask

  task automatic run_case(input int k, input int code, input int per, input int duty);
    int sc, hi, n, e;
    sc = 1 << (2 * code);
    wr(1, 0);
    wr(0, (k << 2) | code);
    wr(k == 0 ? 2 : 4, per);
    wr(k == 0 ? 3 : 5, duty);
    wr(1, k == 0 ? 16'h1200 : 16'h0012);
    check($sformatf("R5 oe k=%0d", k), int'(pwm_oe[k]), 1);
    n = 2 * (per + 1) * sc;
    e = 2 * ((duty < per + 1) ? duty : per + 1) * sc;
    measure(k, n, hi);
    check($sformatf("R2 R3 R4 R6 k=%0d c=%0d p=%0d d=%0d high", k, code, per, duty), hi, e);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int hi;
    int pers[2];
    int duties[4];
    pers[0] = 1; pers[1] = 4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 oe", int'(pwm_oe), 0);
    check("R1 out", int'(pwm_out), 0);

    // sweep both outputs, all prescale codes, several period/duty pairs
    for (int k = 0; k < 2; k++)
      for (int c = 0; c < 4; c++)
        for (int pi = 0; pi < 2; pi++) begin
          duties[0] = 0; duties[1] = 1; duties[2] = pers[pi]; duties[3] = pers[pi] + 3;
          for (int di = 0; di < 4; di++) run_case(k, c, pers[pi], duties[di]);
        end

    // R9: output 1 running on period A
    for (int c = 0; c < 3; c++) begin
      wr(1, 0);
      wr(0, c);
      wr(2, 5); wr(3, 2); wr(4, 1); wr(5, 3);
      wr(1, 16'h1212);
      measure(1, 2 * 6 * (1 << (2 * c)), hi);
      check($sformatf("R9 c=%0d high", c), hi, 2 * 3 * (1 << (2 * c)));
    end

    // R7: control write while running is dropped
    run_case(0, 0, 3, 2);
    wr(0, 3'b111);
    wr(1, 0);
    wr(1, 16'h1200);
    measure(0, 8, hi);
    check("R7 ctrl kept high", hi, 4);

    // R6 stop: both off
    wr(1, 0);
    check("R6 stopped oe", int'(pwm_oe), 0);
    check("R6 stopped out", int'(pwm_out), 0);

    // R5: unknown code keeps output off
    wr(1, 16'h5500);
    check("R5 bad code oe", int'(pwm_oe), 0);
    check("R5 bad code out", int'(pwm_out), 0);
    wr(1, 16'h0013);
    check("R5 bad code oe1", int'(pwm_oe), 0);

    // R8: unbuffered duty write while running
    run_case(0, 0, 3, 0);
    wr(3, 5);
    measure(0, 8, hi);
    check("R8 live duty high", hi, 8);
    wr(3, 1);
    @(negedge clk);
    measure(0, 8, hi);
    check("R8 live duty lowered", hi, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule